// File: doc/BRIEF.md
# Priority-Based Module Load Allocator

This block decides which reconfigurable logic modules the local device loads into its reconfigurable regions. It holds a per-phase priority table and a per-phase default list of modules. It also receives the set of modules that other devices already run, and it keeps its own record of which local regions still work. When the mission phase changes, or when a region is reported broken, it runs an allocation pass. The pass builds a candidate list and places candidates into healthy regions, best priority first. Load requests go out one at a time over a request/done handshake. At the end of the pass the block announces the set of modules it loaded.

Every pass rebuilds the placement from scratch. A module that stays wanted across a phase change is requested again, so its region is refreshed. A module that no longer finds a healthy region is dropped, while higher-priority modules keep their places. A load that reports failure retires its region, and the scan continues with the same module.

Top module: `modload_alloc`

## Requirements
- R1: After reset no request is pending, busy and announce are low, the loaded set and the candidate list are zero, all regions read healthy, and the stored phase is 0.
- R2: At the start of a pass the candidate list becomes: default bit of module m in phase p (bit p*NUM_MODS+m of the default table) AND NOT remote-running bit m AND priority of m in phase p nonzero. The priority is the PRIO_W-bit field at bit offset (p*NUM_MODS+m)*PRIO_W of the priority table. Bit m of every module vector stands for module m. A stored phase code at or above NUM_PHASES yields an empty list.
- R3: Candidates are requested in ascending priority number (1 is most important). Equal numbers go lower module index first. A priority of 0 is never placed.
- R4: Each request targets the lowest-index region that is healthy and not yet filled in the current pass. No region is filled twice in one pass, and an unhealthy region is never requested.
- R5: When no healthy free region remains, the remaining candidates are dropped. The loaded set never holds more modules than there are regions.
- R6: A request stays asserted, with module and region unchanged, until done is seen.
- R7: A done with the ok flag low marks the requested region unhealthy at the next edge. The same module is then requested in the next usable region.
- R8: A failure report marks the named region unhealthy at the next edge and starts a full reallocation pass.
- R9: A phase-change pulse stores the new phase and starts a full pass under it. Modules wanted in both the old and the new phase are requested again.
- R10: At the end of a pass the loaded output takes exactly the modules that completed with ok, and announce pulses for one cycle.
- R11: A trigger that arrives while a pass runs does not abort it. The pass finishes without announcing, and a new pass then runs under the updated phase and health, and only that pass announces.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| phase_i | input | PH_W (2) | Mission phase code, taken on phase_chg_i |
| phase_chg_i | input | 1 | Phase-change trigger pulse |
| fail_i | input | 1 | Region failure report pulse |
| fail_region_i | input | REG_W (2) | Region named by the failure report |
| dflt_tbl_i | input | NUM_PHASES*NUM_MODS (36) | Default load bits, one row per phase |
| prio_tbl_i | input | NUM_PHASES*NUM_MODS*PRIO_W (144) | Priority fields, one per phase and module |
| remote_run_i | input | NUM_MODS (12) | Modules already running on other devices |
| req_valid_o | output | 1 | Load request pending |
| req_mod_o | output | MOD_W (4) | Module index to load |
| req_region_o | output | REG_W (2) | Target region index |
| ld_done_i | input | 1 | Load finished (one cycle) |
| ld_ok_i | input | 1 | Load succeeded, valid with ld_done_i |
| load_list_o | output | NUM_MODS (12) | Candidate list of the latest pass |
| loaded_o | output | NUM_MODS (12) | Modules loaded by the latest announced pass |
| announce_o | output | 1 | One-cycle pulse: loaded_o is fresh |
| busy_o | output | 1 | An allocation pass is running |
| region_ok_o | output | NUM_REGIONS (4) | Healthy-region map |

## Verification
Two functions can fall in the same cycle: a region failure report and the completion of a load into that same region. The bench provokes this by driving fail_i for region 0 in the exact cycle it answers the first request (region 0) with a successful done. It then judges that only one announce follows, that this announce carries the placement computed over regions 1 to 3, and that region 0 reads unhealthy. Randomised tables, remote sets and failed-load injections across all phases are compared request by request with an arithmetic model in the bench.

// File: rtl/modalloc_pkg.sv
package modalloc_pkg;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_START = 3'd1,
      ST_PICK  = 3'd2,
      ST_REQ   = 3'd3,
      ST_DONE  = 3'd4
   } alloc_st_e;

endpackage

// File: rtl/modalloc_cand.sv
// Selects the table row of the stored phase and forms the candidate vector.
module modalloc_cand #(
   parameter int NUM_MODS   = 12,
   parameter int NUM_PHASES = 3,
   parameter int PRIO_W     = 4,
   parameter int PH_W       = 2
) (
   input  logic [PH_W-1:0]                      phase,
   input  logic [NUM_PHASES*NUM_MODS-1:0]        dflt_tbl,
   input  logic [NUM_PHASES*NUM_MODS*PRIO_W-1:0] prio_tbl,
   input  logic [NUM_MODS-1:0]                   remote,
   output logic [NUM_MODS-1:0]                   cand,
   output logic [NUM_MODS*PRIO_W-1:0]            prio_row
);

   for (genvar m = 0; m < NUM_MODS; m++) begin : g_mod
      logic              dflt_bit;
      logic [PRIO_W-1:0] prio_fld;

      always_comb begin
         dflt_bit = 1'b0;
         prio_fld = '0;
         for (int p = 0; p < NUM_PHASES; p++) begin
            if (phase == PH_W'(p)) begin
               dflt_bit = dflt_tbl[p*NUM_MODS + m];
               prio_fld = prio_tbl[(p*NUM_MODS + m)*PRIO_W +: PRIO_W];
            end
         end
      end

      assign cand[m] = dflt_bit & ~remote[m] & (prio_fld != '0);
      assign prio_row[m*PRIO_W +: PRIO_W] = prio_fld;
   end

endmodule

// File: rtl/modalloc_pick.sv
// Finds the pending module with the smallest priority number; lower index wins ties.
module modalloc_pick #(
   parameter int NUM_MODS = 12,
   parameter int PRIO_W   = 4,
   parameter int MOD_W    = 4
) (
   input  logic [NUM_MODS-1:0]        pending,
   input  logic [NUM_MODS*PRIO_W-1:0] prio_row,
   output logic                       found,
   output logic [MOD_W-1:0]           idx
);

   logic [PRIO_W-1:0] best;

   always_comb begin
      found = 1'b0;
      idx   = '0;
      best  = '1;
      for (int m = 0; m < NUM_MODS; m++) begin
         if (pending[m] &&
             (!found || prio_row[m*PRIO_W +: PRIO_W] < best)) begin
            found = 1'b1;
            idx   = MOD_W'(m);
            best  = prio_row[m*PRIO_W +: PRIO_W];
         end
      end
   end

endmodule

// File: rtl/modalloc_region.sv
// Lowest-index available region.
module modalloc_region #(
   parameter int NUM_REGIONS = 4,
   parameter int REG_W       = 2
) (
   input  logic [NUM_REGIONS-1:0] avail,
   output logic                   found,
   output logic [REG_W-1:0]       idx
);

   always_comb begin
      found = 1'b0;
      idx   = '0;
      for (int r = NUM_REGIONS - 1; r >= 0; r--) begin
         if (avail[r]) begin
            found = 1'b1;
            idx   = REG_W'(r);
         end
      end
   end

endmodule

// File: rtl/modload_alloc.sv
module modload_alloc
   import modalloc_pkg::*;
#(
   parameter int NUM_MODS    = 12,
   parameter int NUM_PHASES  = 3,
   parameter int NUM_REGIONS = 4,
   parameter int PRIO_W      = 4,
   localparam int MOD_W      = $clog2(NUM_MODS),
   localparam int REG_W      = $clog2(NUM_REGIONS),
   localparam int PH_W       = $clog2(NUM_PHASES)
) (
   input  logic                                  clk,
   input  logic                                  rst_n,
   input  logic [PH_W-1:0]                       phase_i,
   input  logic                                  phase_chg_i,
   input  logic                                  fail_i,
   input  logic [REG_W-1:0]                      fail_region_i,
   input  logic [NUM_PHASES*NUM_MODS-1:0]        dflt_tbl_i,
   input  logic [NUM_PHASES*NUM_MODS*PRIO_W-1:0] prio_tbl_i,
   input  logic [NUM_MODS-1:0]                   remote_run_i,
   output logic                                  req_valid_o,
   output logic [MOD_W-1:0]                      req_mod_o,
   output logic [REG_W-1:0]                      req_region_o,
   input  logic                                  ld_done_i,
   input  logic                                  ld_ok_i,
   output logic [NUM_MODS-1:0]                   load_list_o,
   output logic [NUM_MODS-1:0]                   loaded_o,
   output logic                                  announce_o,
   output logic                                  busy_o,
   output logic [NUM_REGIONS-1:0]                region_ok_o
);

   // ---------------- elaboration checks ----------------
   if (NUM_MODS < 2) begin : g_chk_mods
      $error("modload_alloc: NUM_MODS must be at least 2");
   end
   if (NUM_REGIONS < 2) begin : g_chk_regs
      $error("modload_alloc: NUM_REGIONS must be at least 2");
   end
   if (NUM_PHASES < 2) begin : g_chk_ph
      $error("modload_alloc: NUM_PHASES must be at least 2");
   end
   if (PRIO_W < 1) begin : g_chk_pw
      $error("modload_alloc: PRIO_W must be at least 1");
   end

   // ---------------- state ----------------
   alloc_st_e               state_q;
   logic [PH_W-1:0]         phase_q;
   logic                    restart_q;
   logic [NUM_MODS-1:0]     pending_q;
   logic [NUM_MODS-1:0]     acc_q;
   logic [NUM_REGIONS-1:0]  used_q;
   logic [NUM_MODS-1:0]     load_list_q;
   logic [NUM_MODS-1:0]     loaded_q;
   logic                    announce_q;
   logic [NUM_REGIONS-1:0]  region_ok_q;
   logic [MOD_W-1:0]        req_mod_q;
   logic [REG_W-1:0]        req_reg_q;

   logic                    trig;
   logic                    load_bad;
   logic [NUM_REGIONS-1:0]  region_ok_n;
   logic [NUM_MODS-1:0]     cand;
   logic [NUM_MODS*PRIO_W-1:0] prio_row;
   logic                    mod_found;
   logic [MOD_W-1:0]        mod_idx;
   logic                    reg_found;
   logic [REG_W-1:0]        reg_idx;

   assign trig     = phase_chg_i | fail_i;
   assign load_bad = (state_q == ST_REQ) && ld_done_i && !ld_ok_i;

   always_comb begin
      region_ok_n = region_ok_q;
      if (load_bad) region_ok_n[req_reg_q] = 1'b0;
      if (fail_i && (int'(fail_region_i) < NUM_REGIONS))
         region_ok_n[fail_region_i] = 1'b0;
   end

   // ---------------- datapath ----------------
   modalloc_cand #(
      .NUM_MODS  (NUM_MODS),
      .NUM_PHASES(NUM_PHASES),
      .PRIO_W    (PRIO_W),
      .PH_W      (PH_W)
   ) i_cand (
      .phase   (phase_q),
      .dflt_tbl(dflt_tbl_i),
      .prio_tbl(prio_tbl_i),
      .remote  (remote_run_i),
      .cand    (cand),
      .prio_row(prio_row)
   );

   modalloc_pick #(
      .NUM_MODS(NUM_MODS),
      .PRIO_W  (PRIO_W),
      .MOD_W   (MOD_W)
   ) i_pick (
      .pending (pending_q),
      .prio_row(prio_row),
      .found   (mod_found),
      .idx     (mod_idx)
   );

   modalloc_region #(
      .NUM_REGIONS(NUM_REGIONS),
      .REG_W      (REG_W)
   ) i_region (
      .avail(region_ok_n & ~used_q),
      .found(reg_found),
      .idx  (reg_idx)
   );

   // ---------------- control ----------------
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q     <= ST_IDLE;
         phase_q     <= '0;
         restart_q   <= 1'b0;
         pending_q   <= '0;
         acc_q       <= '0;
         used_q      <= '0;
         load_list_q <= '0;
         loaded_q    <= '0;
         announce_q  <= 1'b0;
         region_ok_q <= '1;
         req_mod_q   <= '0;
         req_reg_q   <= '0;
      end else begin
         region_ok_q <= region_ok_n;
         announce_q  <= 1'b0;
         if (phase_chg_i) phase_q <= phase_i;
         if (trig && state_q != ST_IDLE) restart_q <= 1'b1;

         case (state_q)
            ST_IDLE: begin
               if (trig) state_q <= ST_START;
            end
            ST_START: begin
               pending_q   <= cand;
               load_list_q <= cand;
               acc_q       <= '0;
               used_q      <= '0;
               restart_q   <= trig;
               state_q     <= ST_PICK;
            end
            ST_PICK: begin
               if (mod_found && reg_found) begin
                  req_mod_q <= mod_idx;
                  req_reg_q <= reg_idx;
                  state_q   <= ST_REQ;
               end else begin
                  state_q   <= ST_DONE;
               end
            end
            ST_REQ: begin
               if (ld_done_i) begin
                  if (ld_ok_i) begin
                     acc_q     <= acc_q | (NUM_MODS'(1) << req_mod_q);
                     used_q    <= used_q | (NUM_REGIONS'(1) << req_reg_q);
                     pending_q <= pending_q & ~(NUM_MODS'(1) << req_mod_q);
                  end
                  state_q <= ST_PICK;
               end
            end
            ST_DONE: begin
               if (restart_q || trig) begin
                  state_q <= ST_START;
               end else begin
                  loaded_q   <= acc_q;
                  announce_q <= 1'b1;
                  state_q    <= ST_IDLE;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign req_valid_o  = (state_q == ST_REQ);
   assign req_mod_o    = req_mod_q;
   assign req_region_o = req_reg_q;
   assign load_list_o  = load_list_q;
   assign loaded_o     = loaded_q;
   assign announce_o   = announce_q;
   assign busy_o       = (state_q != ST_IDLE);
   assign region_ok_o  = region_ok_q;

   // ---------------- assertions ----------------
   // R4: a fresh request never targets an unhealthy or already filled region
   a_r4_req_region_usable: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(req_valid_o) |-> (region_ok_o[req_region_o] && !used_q[req_region_o]));

   // R3: the requested module belongs to the candidate list of the pass
   a_r3_req_in_list: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid_o |-> load_list_o[req_mod_o]);

   // R6: request held with stable fields until done
   a_r6_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid_o && !ld_done_i) |=>
         (req_valid_o && $stable(req_mod_o) && $stable(req_region_o)));

   // R7: failed load retires its region
   a_r7_bad_load_retires: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid_o && ld_done_i && !ld_ok_i) |=> !region_ok_o[$past(req_region_o)]);

   // R8: failure report retires the region and leaves the block busy
   a_r8_report_retires: assert property (@(posedge clk) disable iff (!rst_n)
      fail_i |=> (!region_ok_o[$past(fail_region_i)] && busy_o));

   // R5, R10: announced set is a subset of the list and fits the regions
   a_r5_announce_fits: assert property (@(posedge clk) disable iff (!rst_n)
      announce_o |-> (((loaded_o & ~load_list_o) == '0) &&
                      ($countones(loaded_o) <= NUM_REGIONS)));

   // R10: announce is a single-cycle pulse, only at the end of a pass
   a_r10_announce_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      announce_o |=> !announce_o);

   a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> !req_valid_o);

endmodule

// File: tb/test_modload_alloc.sv
`timescale 1ns/1ps
module test_modload_alloc;

   localparam int NM = 12;
   localparam int NP = 3;
   localparam int NR = 4;
   localparam int PW = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;

   logic [1:0]          phase_i = '0;
   logic                phase_chg_i = 1'b0;
   logic                fail_i = 1'b0;
   logic [1:0]          fail_region_i = '0;
   logic [NP*NM-1:0]    dflt_tbl = '0;
   logic [NP*NM*PW-1:0] prio_tbl = '0;
   logic [NM-1:0]       remote = '0;
   logic                req_valid_o;
   logic [3:0]          req_mod_o;
   logic [1:0]          req_region_o;
   logic                ld_done_i = 1'b0;
   logic                ld_ok_i = 1'b0;
   logic [NM-1:0]       load_list_o;
   logic [NM-1:0]       loaded_o;
   logic                announce_o;
   logic                busy_o;
   logic [NR-1:0]       region_ok_o;

   modload_alloc #(.NUM_MODS(NM), .NUM_PHASES(NP), .NUM_REGIONS(NR), .PRIO_W(PW))
   i_modload_alloc (
      .clk(clk), .rst_n(rst_n), .phase_i(phase_i), .phase_chg_i(phase_chg_i),
      .fail_i(fail_i), .fail_region_i(fail_region_i), .dflt_tbl_i(dflt_tbl),
      .prio_tbl_i(prio_tbl), .remote_run_i(remote), .req_valid_o(req_valid_o),
      .req_mod_o(req_mod_o), .req_region_o(req_region_o), .ld_done_i(ld_done_i),
      .ld_ok_i(ld_ok_i), .load_list_o(load_list_o), .loaded_o(loaded_o),
      .announce_o(announce_o), .busy_o(busy_o), .region_ok_o(region_ok_o)
   );

   int n_tests = 0;
   int n_fail  = 0;

   task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                      input logic [31:0] exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   logic [31:0] seed = 32'h1b3c5d7f;
   task automatic rnd(output logic [31:0] v);
      seed = seed ^ (seed << 13);
      seed = seed ^ (seed >> 17);
      seed = seed ^ (seed << 5);
      v = seed;
   endtask

   function automatic int prio_of(int ph, int m);
      return int'(prio_tbl[(ph*NM + m)*PW +: PW]);
   endfunction

   function automatic logic [NM-1:0] cand_of(int ph);
      logic [NM-1:0] c = '0;
      if (ph >= NP) return '0;
      for (int m = 0; m < NM; m++)
         c[m] = dflt_tbl[ph*NM + m] && !remote[m] && (prio_of(ph, m) != 0);
      return c;
   endfunction

   // expected placement
   logic [NM-1:0] e_loaded;
   logic [NR-1:0] e_ok;
   int            e_n;
   int            e_mod [16];
   int            e_reg [16];

   task automatic model(input logic [NM-1:0] cnd, input int ph,
                        input logic [NR-1:0] ok_in, input logic [NR-1:0] lf);
      logic [NM-1:0] pend = cnd;
      logic [NR-1:0] ok = ok_in;
      logic [NR-1:0] used = '0;
      e_loaded = '0;
      e_n = 0;
      for (int step = 0; step < 16; step++) begin
         int bm = -1;
         int bp = 99;
         int br = -1;
         for (int m = 0; m < NM; m++)
            if (pend[m] && prio_of(ph, m) < bp) begin
               bm = m;
               bp = prio_of(ph, m);
            end
         for (int r = NR - 1; r >= 0; r--)
            if (ok[r] && !used[r]) br = r;
         if (bm < 0 || br < 0) break;
         e_mod[e_n] = bm;
         e_reg[e_n] = br;
         e_n++;
         if (lf[br]) ok[br] = 1'b0;
         else begin
            used[br] = 1'b1;
            e_loaded[bm] = 1'b1;
            pend[bm] = 1'b0;
         end
      end
      e_ok = ok;
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      fail_i = 1'b0;
      phase_chg_i = 1'b0;
      ld_done_i = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic trig_phase(input int ph);
      @(negedge clk);
      phase_i = 2'(ph);
      phase_chg_i = 1'b1;
      @(negedge clk);
      phase_chg_i = 1'b0;
   endtask

   task automatic trig_fail(input int r);
      @(negedge clk);
      fail_i = 1'b1;
      fail_region_i = 2'(r);
      @(negedge clk);
      fail_i = 1'b0;
   endtask

   // answers requests until an announce; conc >= 0 injects a failure report
   // for that region in the same cycle as the first done
   task automatic respond(input bit chkseq, input logic [NR-1:0] lf,
                          input string tag, input int conc);
      int  k = 0;
      bit  got = 1'b0;
      for (int cyc = 0; cyc < 400 && !got; cyc++) begin
         @(negedge clk);
         if (announce_o) got = 1'b1;
         else if (req_valid_o) begin
            logic [3:0] m0 = req_mod_o;
            logic [1:0] r0 = req_region_o;
            if (chkseq)
               chk(k < e_n && int'(req_mod_o) == e_mod[k] && int'(req_region_o) == e_reg[k],
                   {tag, " order R3 R4"}, {24'd0, req_mod_o, 2'd0, req_region_o},
                   (k < e_n) ? 32'(e_mod[k]*16 + e_reg[k]) : 32'hffff);
            for (int d = 0; d < k % 3; d++) begin
               @(negedge clk);
               chk(req_valid_o && req_mod_o == m0 && req_region_o == r0,
                   {tag, " R6 hold"}, {27'd0, req_valid_o, req_mod_o}, {28'd1, m0});
            end
            k++;
            ld_done_i = 1'b1;
            ld_ok_i = !lf[req_region_o];
            if (conc >= 0 && k == 1) begin
               fail_i = 1'b1;
               fail_region_i = 2'(conc);
            end
            @(negedge clk);
            ld_done_i = 1'b0;
            fail_i = 1'b0;
         end
      end
      chk(got, {tag, " R10 announce seen"}, 32'(got), 1);
      if (chkseq) chk(k == e_n, {tag, " R5 request count"}, 32'(k), 32'(e_n));
   endtask

   task automatic post(input string tag, input logic [NM-1:0] cnd);
      chk(load_list_o == cnd, {tag, " R2 list"}, 32'(load_list_o), 32'(cnd));
      chk(loaded_o == e_loaded, {tag, " R10 loaded"}, 32'(loaded_o), 32'(e_loaded));
      chk(region_ok_o == e_ok, {tag, " R7 health"}, 32'(region_ok_o), 32'(e_ok));
      chk(!busy_o && !req_valid_o, {tag, " R5 idle"}, 32'(busy_o), 0);
   endtask

   task automatic finish_up();
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      chk(1'b0, "watchdog", 0, 1);
      finish_up();
   end

   initial begin
      logic [31:0] a, b, c;
      logic [NR-1:0] lf;

      // R1 reset state
      do_reset();
      @(negedge clk);
      chk(!req_valid_o && !busy_o && !announce_o, "R1 control idle",
          {29'd0, req_valid_o, busy_o, announce_o}, 0);
      chk(loaded_o == '0 && load_list_o == '0, "R1 vectors clear",
          {loaded_o, load_list_o}, 0);
      chk(region_ok_o == '1, "R1 regions healthy", 32'(region_ok_o), 32'hf);

      // random sweep across phases, with failed-load injection (R2 R3 R4 R5 R7)
      for (int ph = 0; ph < NP; ph++) begin
         for (int s = 0; s < 12; s++) begin
            do_reset();
            for (int i = 0; i < NP*NM; i++) begin
               rnd(a);
               prio_tbl[i*PW +: PW] = PW'(a % 6);
            end
            rnd(a); rnd(b); rnd(c);
            dflt_tbl = 36'(a) | 36'(b);
            remote = NM'(a & b & c);
            rnd(a); rnd(b);
            lf = (s % 3 == 0) ? ((a[3:0] & b[3:0]) | 4'b0001) : 4'b0000;
            trig_phase(ph);
            model(cand_of(ph), ph, 4'hf, lf);
            respond(1'b1, lf, $sformatf("sweep p%0d s%0d", ph, s), -1);
            post($sformatf("sweep p%0d s%0d", ph, s), cand_of(ph));
         end
      end

      // R3 tie break: equal priorities go in index order
      do_reset();
      remote = '0;
      dflt_tbl = '1;
      for (int i = 0; i < NP*NM; i++) prio_tbl[i*PW +: PW] = 4'd3;
      prio_tbl[(0*NM + 9)*PW +: PW] = 4'd1;
      trig_phase(0);
      model(cand_of(0), 0, 4'hf, 4'h0);
      chk(e_loaded == 12'h207, "R3 tie model", 32'(e_loaded), 32'h207);
      respond(1'b1, 4'h0, "tie", -1);
      post("tie", cand_of(0));

      // R9 phase change reloads overlapping modules
      dflt_tbl[1*NM +: NM] = 12'h0fc;
      trig_phase(1);
      model(cand_of(1), 1, region_ok_o, 4'h0);
      respond(1'b1, 4'h0, "R9 phase", -1);
      post("R9 phase", cand_of(1));
      chk(loaded_o == 12'h03c, "R9 overlap reloaded", 32'(loaded_o), 32'h03c);

      // R8 failure report while idle
      trig_fail(1);
      model(cand_of(1), 1, 4'b1101, 4'h0);
      respond(1'b1, 4'h0, "R8 report", -1);
      post("R8 report", cand_of(1));

      // R2 out-of-range phase code gives an empty list
      trig_phase(3);
      model('0, 3, region_ok_o, 4'h0);
      respond(1'b1, 4'h0, "R2 bad phase", -1);
      post("R2 bad phase", '0);

      // R11 failure report in the same cycle as a good done on that region
      do_reset();
      dflt_tbl = '1;
      for (int i = 0; i < NP*NM; i++) begin
         rnd(a);
         prio_tbl[i*PW +: PW] = PW'(1 + a % 5);
      end
      trig_phase(0);
      model(cand_of(0), 0, 4'b1110, 4'h0);
      respond(1'b0, 4'h0, "R11 same cycle", 0);
      post("R11 same cycle", cand_of(0));
      repeat (4) @(negedge clk);
      chk(!announce_o && !busy_o, "R11 single announce", {30'd0, announce_o, busy_o}, 0);

      finish_up();
   end

endmodule